// File: doc/BRIEF.md
# Load-Use Stall Controller

This block watches the instruction held between fetch and decode and the instruction sitting between decode and execute. When the older one is a load whose destination register is needed as a source by the younger one, the loaded value cannot arrive in time, because it only comes out of the memory stage and forwarding cannot reach back far enough. The block then holds the program counter and the fetch/decode register for one cycle and sends an empty instruction, a bubble, into the execute stage.

A small model of the front of the pipeline is part of the block. It contains the program counter, the fetch/decode register and the decode/execute register. Outside logic supplies the decoded fields of the instruction at the current program counter. On every cycle the model either advances all three registers or holds the first two and sends a bubble down. The control word of an instruction is packed as follows, from the least significant bit up: `EXW` execute-select bits, then memory-read, memory-write, register-write and write-back-select. With the default `EXW = 2`, memory-read is bit 2.

Top module: `loaduse_stall_ctl`

## Requirements
- R1: While reset is asserted and after it, the program counter is `PC_RESET` (0) and both control words (`ifid_ctrl_o`, `idex_ctrl_o`) are zero, so the pipeline holds no-ops.
- R2: `bubble_o` is high exactly when the decode/execute memory-read bit (bit `EXW`) is set, `idex_rd_o` is nonzero, and `idex_rd_o` equals `ifid_rs1_o` or `ifid_rs2_o`.
- R3: A load whose destination is register 0 never causes a stall, even when a following source field is 0.
- R4: In a hazard cycle `pc_we_o` and `ifid_we_o` are low, and after the edge `pc_o` and every fetch/decode field keep their previous values.
- R5: In the cycle after a hazard, `idex_ctrl_o` is all zero, so the execute, memory and write-back control fields are cleared.
- R6: In a hazard cycle the register-number fields of the decode/execute register are still loaded from the fetch/decode register.
- R7: Without a hazard, `pc_o` advances by `PC_STEP` (4), the fetch/decode register takes the fetch inputs, and the decode/execute register takes the fetch/decode fields unchanged.
- R8: A stall lasts one cycle. After a bubble, `bubble_o` is low in the next cycle, and the held instruction moves on.
- R9: A register match with an older instruction whose memory-read bit is clear, such as an ALU operation or a store, causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_rs1_i | input | RW | First source register of the instruction at `pc_o` |
| fetch_rs2_i | input | RW | Second source register of the instruction at `pc_o` |
| fetch_rd_i | input | RW | Destination register of the instruction at `pc_o` |
| fetch_ctrl_i | input | EXW+4 | Control word of the instruction at `pc_o` |
| pc_o | output | PCW | Program counter |
| pc_we_o | output | 1 | Program counter update enable |
| ifid_we_o | output | 1 | Fetch/decode register load enable |
| bubble_o | output | 1 | Selects a zero control word into decode/execute |
| ifid_rs1_o | output | RW | Fetch/decode first source |
| ifid_rs2_o | output | RW | Fetch/decode second source |
| ifid_rd_o | output | RW | Fetch/decode destination |
| ifid_ctrl_o | output | EXW+4 | Fetch/decode control word |
| idex_rs1_o | output | RW | Decode/execute first source |
| idex_rs2_o | output | RW | Decode/execute second source |
| idex_rd_o | output | RW | Decode/execute destination |
| idex_ctrl_o | output | EXW+4 | Decode/execute control word |

## Verification
The stall controls (`bubble_o`, `pc_we_o`, `ifid_we_o`) are combinational from the registered fields, so they are due in the same cycle as the register state that causes them. The held program counter, the frozen fetch/decode fields and the cleared decode/execute control word are due one edge later. The reference model in the bench advances once per cycle and compares every output half a period after each rising edge. The result caused by a hazard is therefore checked in the sample right after the edge that acted on it, and the check carries the tag of the hazard rule (R4, R5, R6 or R8) instead of the normal-advance rule.

// File: rtl/loaduse_stall_ctl.sv
module loaduse_stall_ctl #(
  parameter int PCW      = 32,
  parameter int RW       = 5,
  parameter int EXW      = 2,
  parameter int PC_STEP  = 4,
  parameter int PC_RESET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    fetch_rs1_i,
  input  logic [RW-1:0]    fetch_rs2_i,
  input  logic [RW-1:0]    fetch_rd_i,
  input  logic [EXW+3:0]   fetch_ctrl_i,
  output logic [PCW-1:0]   pc_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o,
  output logic [RW-1:0]    ifid_rs1_o,
  output logic [RW-1:0]    ifid_rs2_o,
  output logic [RW-1:0]    ifid_rd_o,
  output logic [EXW+3:0]   ifid_ctrl_o,
  output logic [RW-1:0]    idex_rs1_o,
  output logic [RW-1:0]    idex_rs2_o,
  output logic [RW-1:0]    idex_rd_o,
  output logic [EXW+3:0]   idex_ctrl_o
);
  localparam int CW     = EXW + 4;
  localparam int MR_BIT = EXW;

  logic dest_live, src_hit;

  assign dest_live = idex_ctrl_o[MR_BIT] && (idex_rd_o != '0);
  assign src_hit   = (idex_rd_o == ifid_rs1_o) || (idex_rd_o == ifid_rs2_o);
  assign bubble_o  = dest_live && src_hit;
  assign pc_we_o   = !bubble_o;
  assign ifid_we_o = !bubble_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o <= PCW'(PC_RESET);
    end else if (pc_we_o) begin
      pc_o <= pc_o + PCW'(PC_STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifid_rs1_o  <= '0;
      ifid_rs2_o  <= '0;
      ifid_rd_o   <= '0;
      ifid_ctrl_o <= '0;
    end else if (ifid_we_o) begin
      ifid_rs1_o  <= fetch_rs1_i;
      ifid_rs2_o  <= fetch_rs2_i;
      ifid_rd_o   <= fetch_rd_i;
      ifid_ctrl_o <= fetch_ctrl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idex_rs1_o  <= '0;
      idex_rs2_o  <= '0;
      idex_rd_o   <= '0;
      idex_ctrl_o <= '0;
    end else begin
      idex_rs1_o  <= ifid_rs1_o;
      idex_rs2_o  <= ifid_rs2_o;
      idex_rd_o   <= ifid_rd_o;
      idex_ctrl_o <= bubble_o ? CW'(0) : ifid_ctrl_o;
    end
  end
endmodule

module loaduse_stall_chk #(
  parameter int PCW     = 32,
  parameter int RW      = 5,
  parameter int EXW     = 2,
  parameter int PC_STEP = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PCW-1:0] pc_o,
  input logic           bubble_o,
  input logic [RW-1:0]  ifid_rs1_o,
  input logic [RW-1:0]  ifid_rs2_o,
  input logic [RW-1:0]  ifid_rd_o,
  input logic [EXW+3:0] ifid_ctrl_o,
  input logic [RW-1:0]  idex_rd_o,
  input logic [EXW+3:0] idex_ctrl_o
);
  // R2
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_ctrl_o[EXW] |-> !bubble_o);
  // R3
  zero_dest_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rd_o == '0) |-> !bubble_o);
  // R4
  front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> (pc_o == $past(pc_o)) && (ifid_rs1_o == $past(ifid_rs1_o)) &&
                 (ifid_rs2_o == $past(ifid_rs2_o)) && (ifid_rd_o == $past(ifid_rd_o)) &&
                 (ifid_ctrl_o == $past(ifid_ctrl_o)));
  // R5
  bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> (idex_ctrl_o == '0));
  // R6
  bubble_regnum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> (idex_rd_o == $past(ifid_rd_o)));
  // R7
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_o |=> (pc_o == $past(pc_o) + PCW'(PC_STEP)));
  // R8
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> !bubble_o);
endmodule

bind loaduse_stall_ctl loaduse_stall_chk #(
  .PCW(PCW), .RW(RW), .EXW(EXW), .PC_STEP(PC_STEP)
) u_stall_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .bubble_o(bubble_o),
  .ifid_rs1_o(ifid_rs1_o), .ifid_rs2_o(ifid_rs2_o), .ifid_rd_o(ifid_rd_o),
  .ifid_ctrl_o(ifid_ctrl_o), .idex_rd_o(idex_rd_o), .idex_ctrl_o(idex_ctrl_o)
);

// File: tb/test_loaduse_stall_ctl.sv
module test_loaduse_stall_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 16;
  localparam logic [5:0] C_LD  = 6'b110100;
  localparam logic [5:0] C_ALU = 6'b010010;
  localparam logic [5:0] C_ST  = 6'b001000;

  logic clk = 0, rst_n = 0;
  logic [4:0] f_rs1, f_rs2, f_rd;
  logic [5:0] f_ctrl;
  logic [31:0] pc;
  logic pc_we, ifid_we, bubble;
  logic [4:0] d_rs1, d_rs2, d_rd, e_rs1, e_rs2, e_rd;
  logic [5:0] d_ctrl, e_ctrl;

  int p_rs1[NPROG], p_rs2[NPROG], p_rd[NPROG], p_ctrl[NPROG];
  int total = 0, bad = 0, cycles = 0, stalls = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loaduse_stall_ctl i_loaduse_stall_ctl (
    .clk(clk), .rst_n(rst_n),
    .fetch_rs1_i(f_rs1), .fetch_rs2_i(f_rs2), .fetch_rd_i(f_rd), .fetch_ctrl_i(f_ctrl),
    .pc_o(pc), .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble),
    .ifid_rs1_o(d_rs1), .ifid_rs2_o(d_rs2), .ifid_rd_o(d_rd), .ifid_ctrl_o(d_ctrl),
    .idex_rs1_o(e_rs1), .idex_rs2_o(e_rs2), .idex_rd_o(e_rd), .idex_ctrl_o(e_ctrl)
  );

  function automatic int fetch_at(int addr, int which);
    int k = addr / 4;
    if (k >= NPROG) return 0;
    case (which)
      0: return p_rs1[k];
      1: return p_rs2[k];
      2: return p_rd[k];
      default: return p_ctrl[k];
    endcase
  endfunction

  always_comb begin
    f_rs1  = 5'(fetch_at(int'(pc), 0));
    f_rs2  = 5'(fetch_at(int'(pc), 1));
    f_rd   = 5'(fetch_at(int'(pc), 2));
    f_ctrl = 6'(fetch_at(int'(pc), 3));
  end

  task automatic check(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic put(int k, int rs1, int rs2, int rd, int c);
    p_rs1[k] = rs1; p_rs2[k] = rs2; p_rd[k] = rd; p_ctrl[k] = c;
  endtask

  // reference model state
  int m_pc = 0;
  int m_d_rs1 = 0, m_d_rs2 = 0, m_d_rd = 0, m_d_ctrl = 0;
  int m_e_rs1 = 0, m_e_rs2 = 0, m_e_rd = 0, m_e_ctrl = 0;
  bit prev_bub = 0;

  task automatic compare_and_step();
    bit is_load, hit, exp_bub;
    string t_front, t_ctrl, t_num, t_bub;
    is_load = (m_e_ctrl & 4) != 0;
    hit = (m_e_rd == m_d_rs1) || (m_e_rd == m_d_rs2);
    exp_bub = is_load && m_e_rd != 0 && hit;
    t_front = prev_bub ? "R4" : "R7";
    t_ctrl  = prev_bub ? "R5" : "R7";
    t_num   = prev_bub ? "R6" : "R7";
    if (prev_bub) t_bub = "R8";
    else if (hit && is_load && m_e_rd == 0) t_bub = "R3";
    else if (hit && !is_load) t_bub = "R9";
    else t_bub = "R2";
    check(t_bub, "bubble", int'(bubble), int'(exp_bub));
    check("R4", "pc_we", int'(pc_we), int'(!exp_bub));
    check("R4", "ifid_we", int'(ifid_we), int'(!exp_bub));
    check(t_front, "pc", int'(pc), m_pc);
    check(t_front, "ifid_rs1", int'(d_rs1), m_d_rs1);
    check(t_front, "ifid_rs2", int'(d_rs2), m_d_rs2);
    check(t_front, "ifid_rd", int'(d_rd), m_d_rd);
    check(t_front, "ifid_ctrl", int'(d_ctrl), m_d_ctrl);
    check(t_ctrl, "idex_ctrl", int'(e_ctrl), m_e_ctrl);
    check(t_num, "idex_rd", int'(e_rd), m_e_rd);
    check(t_num, "idex_rs1", int'(e_rs1), m_e_rs1);
    check(t_num, "idex_rs2", int'(e_rs2), m_e_rs2);
    if (exp_bub) stalls++;
    m_e_rs1 = m_d_rs1; m_e_rs2 = m_d_rs2; m_e_rd = m_d_rd;
    m_e_ctrl = exp_bub ? 0 : m_d_ctrl;
    if (!exp_bub) begin
      m_d_rs1 = fetch_at(m_pc, 0); m_d_rs2 = fetch_at(m_pc, 1);
      m_d_rd = fetch_at(m_pc, 2);  m_d_ctrl = fetch_at(m_pc, 3);
      m_pc = m_pc + 4;
    end
    prev_bub = exp_bub;
  endtask

  initial begin
    put(0, 1, 0, 5, C_LD);
    put(1, 5, 2, 6, C_ALU);     // stall on rs1
    put(2, 3, 0, 7, C_LD);
    put(3, 1, 7, 8, C_ALU);     // stall on rs2
    put(4, 2, 0, 0, C_LD);
    put(5, 0, 0, 9, C_ALU);     // R3: destination zero
    put(6, 4, 0, 10, C_LD);
    put(7, 12, 13, 11, C_ALU);  // independent
    put(8, 2, 14, 14, C_ST);
    put(9, 14, 1, 15, C_ALU);   // R9: store producer
    put(10, 3, 4, 16, C_ALU);
    put(11, 16, 16, 17, C_ALU); // R9: ALU producer
    put(12, 1, 0, 18, C_LD);
    put(13, 18, 0, 19, C_LD);   // stall, then itself a load
    put(14, 19, 0, 20, C_ALU);  // stall again
    put(15, 1, 2, 21, C_ALU);
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", int'(pc), 0);
    check("R1", "ifid_ctrl in reset", int'(d_ctrl), 0);
    check("R1", "idex_ctrl in reset", int'(e_ctrl), 0);
    rst_n = 1;
    for (int i = 0; i < 40; i++) begin
      compare_and_step();
      @(negedge clk);
    end
    check("R8", "stall count", stalls, 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 2000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under 2000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule